// File: doc/BRIEF.md
# Slice Translation Buffer with Hardware Table Walk

This block turns virtual addresses from a near-memory processor into physical addresses. It does not use fixed pages. Each cached rule covers a slice: a span of any length that is contiguous in both the virtual and the physical space. A rule holds a virtual base, a physical base and a byte length. The lowest part of the virtual space, below a fixed scratchpad boundary, passes through untranslated and is flagged as scratchpad.

The buffer keeps a small set of rules and replaces them in least-recently-used order. When a request misses, an on-chip walker reads a slice table from memory with no help from the host. It scans the records in order from a programmable table base and installs the first record that covers the address. If no record covers it, the walker returns a fault.

Software sets up two registers: the table base and the number of records. Writing the table base drops every cached rule and resets the replacement order, because a new table means a new task.

Top module: `slice_tlb`

## Requirements
- R1: After reset, reqReady is 1, rspValid and memReqValid are 0, the record count is 0 and no rule is cached. A translated request then faults without any memory read.
- R2: A request with va below SPM_BYTES (0x1000 by default) responds in the next cycle with rspPa = va and rspScratch = 1. It issues no memory read.
- R3: A request that hits a cached rule responds in the next cycle with rspPa = pbase + (va - vbase). It issues no memory read.
- R4: A rule covers va only when vbase <= va < vbase + len. The address vbase + len and the address vbase - 1 are both outside the rule.
- R5: On a miss the walker reads 32-bit words at tableBase + 12*i + 4*w, with w = 0 for the virtual base, w = 1 for the physical base and w = 2 for the length. It reads record i = 0, 1, ... in order and stops after the first record that covers va.
- R6: For a matching record, the response comes one cycle after its length word arrives. The record is installed, so a later request inside the same slice hits.
- R7: If no record among the count covers va, the response has rspFault = 1 and rspPa = 0. No rule is installed. With a count of 0 the fault comes in the next cycle with no read.
- R8: While a walk is in progress, reqReady stays 0.
- R9: A refill goes into the lowest-numbered empty slot. If there is no empty slot, it replaces the least recently used rule. Both hits and refills count as a use.
- R10: Writing the table base (cfgSel = 0) invalidates all rules and resets the replacement order. Writing the record count (cfgSel = 1) leaves the cached rules as they are.
- R11: A memory read request, once raised, stays raised with a stable address until memReqReady accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgSel | input | 1 | 0 selects the table base, 1 selects the record count |
| cfgWrData | input | AW | Configuration write data |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVa | input | AW | Virtual address |
| rspValid | output | 1 | Response valid, one cycle |
| rspPa | output | AW | Physical address |
| rspFault | output | 1 | No rule covers the address |
| rspScratch | output | 1 | Address is in the scratchpad region |
| memReqValid | output | 1 | Table word read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | AW | Byte address of the table word |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |

## Verification
Errors in the cached rules or in the replacement ages surface at the port as read traffic. A rule evicted too early, or one that was never invalidated, changes whether the next request costs zero reads or 3*(k+1) reads. It can also change the returned address. The bench therefore predicts the exact read count, read addresses and response cycle of every request, and walks a fixed sequence that evicts each slot in turn. A wrong age shows up on the first refill after the slot fills up. A wrong range comparison shows up at the first boundary address.

// File: rtl/slice_tlb_pkg.sv
package slice_tlb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} walkState_t;

  typedef struct packed {
    logic lookup;    // request accepted this cycle
    logic flush;     // table base rewritten
    logic capVbase;  // word 0 of a record arrives
    logic capPbase;  // word 1 of a record arrives
    logic fill;      // matching record complete, install it
    logic fault;     // no record matched
  } tlbStrobe_t;
endpackage

// File: rtl/slice_tlb_dp.sv
module slice_tlb_dp
  import slice_tlb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int ENTRIES   = 4,
  parameter int SPM_BYTES = 32'h1000
) (
  input  logic          clk,
  input  logic          rstN,
  input  tlbStrobe_t    strb,
  input  logic [AW-1:0] reqVa,
  input  logic [31:0]   memRspData,
  output logic          lookScratch,
  output logic          lookHit,
  output logic          recMatch,
  output logic [AW-1:0] rspPa
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [AW-1:0]    entVbase [ENTRIES];
  logic [AW-1:0]    entPbase [ENTRIES];
  logic [AW-1:0]    entLen   [ENTRIES];
  logic [IDX_W-1:0] entAge   [ENTRIES];
  logic [ENTRIES-1:0] entValid, hitVec, oldestVec;

  logic [AW-1:0] vaHold, recVbase, recPbase, recLen;
  logic [IDX_W-1:0] hitIdx, victimIdx, touchIdx;
  logic touchEn, anyFree;

  assign recLen = AW'(memRspData);
  assign lookScratch = reqVa < AW'(SPM_BYTES);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    logic [AW-1:0] offset;
    assign offset       = reqVa - entVbase[g];
    assign hitVec[g]    = entValid[g] && (reqVa >= entVbase[g]) && (offset < entLen[g]);
    assign oldestVec[g] = entAge[g] == IDX_W'(ENTRIES - 1);
  end

  assign lookHit  = |hitVec;
  assign recMatch = (vaHold >= recVbase) && ((vaHold - recVbase) < recLen);

  always_comb begin
    hitIdx    = '0;
    victimIdx = '0;
    anyFree   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
      if (oldestVec[i] && !anyFree) victimIdx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        victimIdx = IDX_W'(i);
        anyFree   = 1'b1;
      end
    end
  end

  assign touchEn  = (strb.lookup && lookHit && !lookScratch) || strb.fill;
  assign touchIdx = strb.fill ? victimIdx : hitIdx;

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      entValid <= '0;
      for (int i = 0; i < ENTRIES; i++) entAge[i] <= IDX_W'(i);
    end else begin
      if (touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx) entAge[i] <= '0;
          else if (entAge[i] < entAge[touchIdx]) entAge[i] <= entAge[i] + 1'b1;
        end
      end
      if (strb.fill) begin
        entValid[victimIdx] <= 1'b1;
        entVbase[victimIdx] <= recVbase;
        entPbase[victimIdx] <= recPbase;
        entLen[victimIdx]   <= recLen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaHold   <= '0;
      recVbase <= '0;
      recPbase <= '0;
      rspPa    <= '0;
    end else begin
      if (strb.lookup) begin
        vaHold <= reqVa;
        rspPa  <= lookScratch ? reqVa :
                  (entPbase[hitIdx] + (reqVa - entVbase[hitIdx]));
      end
      if (strb.capVbase) recVbase <= AW'(memRspData);
      if (strb.capPbase) recPbase <= AW'(memRspData);
      if (strb.fill)  rspPa <= recPbase + (vaHold - recVbase);
      if (strb.fault) rspPa <= '0;
    end
  end

  // R9
  victim_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(oldestVec) == 1);

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (entValid == '0));
endmodule

// File: rtl/slice_tlb_ctl.sv
module slice_tlb_ctl
  import slice_tlb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgSel,
  input  logic [AW-1:0] cfgWrData,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          lookScratch,
  input  logic          lookHit,
  input  logic          recMatch,
  output logic          rspValid,
  output logic          rspFault,
  output logic          rspScratch,
  output logic          memReqValid,
  input  logic          memReqReady,
  output logic [AW-1:0] memReqAddr,
  input  logic          memRspValid,
  output tlbStrobe_t    strb
);
  walkState_t state;
  logic [AW-1:0]    tableBase;
  logic [CNT_W-1:0] recCount, recIdx;
  logic [1:0]       wordIdx;
  logic accept, miss, startWalk, gotWord, lastWord, lastRec;

  assign reqReady    = state == ST_IDLE;
  assign accept      = reqValid && reqReady;
  assign miss        = !lookScratch && !lookHit;
  assign startWalk   = accept && miss && (recCount != '0);
  assign memReqValid = state == ST_FETCH;
  assign memReqAddr  = tableBase + AW'(recIdx) * AW'(12) + AW'(wordIdx) * AW'(4);
  assign gotWord     = (state == ST_WAIT) && memRspValid;
  assign lastWord    = gotWord && (wordIdx == 2'd2);
  assign lastRec     = recIdx == (recCount - CNT_W'(1));

  always_comb begin
    strb          = '0;
    strb.lookup   = accept;
    strb.flush    = cfgWrEn && !cfgSel;
    strb.capVbase = gotWord && (wordIdx == 2'd0);
    strb.capPbase = gotWord && (wordIdx == 2'd1);
    strb.fill     = lastWord && recMatch;
    strb.fault    = (lastWord && !recMatch && lastRec) ||
                    (accept && miss && (recCount == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tableBase <= '0;
      recCount  <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) recCount  <= CNT_W'(cfgWrData);
      else        tableBase <= cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      recIdx  <= '0;
      wordIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startWalk) begin
          state   <= ST_FETCH;
          recIdx  <= '0;
          wordIdx <= '0;
        end
        ST_FETCH: if (memReqReady) state <= ST_WAIT;
        ST_WAIT: if (memRspValid) begin
          if (wordIdx != 2'd2) begin
            wordIdx <= wordIdx + 2'd1;
            state   <= ST_FETCH;
          end else if (recMatch || lastRec) begin
            state <= ST_IDLE;
          end else begin
            recIdx  <= recIdx + CNT_W'(1);
            wordIdx <= '0;
            state   <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspFault   <= 1'b0;
      rspScratch <= 1'b0;
    end else begin
      rspValid   <= (accept && !startWalk) || strb.fill || strb.fault;
      rspFault   <= strb.fault;
      rspScratch <= accept && lookScratch;
    end
  end

  // R11
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R5
  rsp_in_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (state == ST_WAIT));
endmodule

// File: rtl/slice_tlb.sv
module slice_tlb
  import slice_tlb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int ENTRIES   = 4,
  parameter int SPM_BYTES = 32'h1000,
  parameter int CNT_W     = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgSel,
  input  logic [AW-1:0] cfgWrData,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqVa,
  output logic          rspValid,
  output logic [AW-1:0] rspPa,
  output logic          rspFault,
  output logic          rspScratch,
  output logic          memReqValid,
  input  logic          memReqReady,
  output logic [AW-1:0] memReqAddr,
  input  logic          memRspValid,
  input  logic [31:0]   memRspData
);
  tlbStrobe_t strb;
  logic lookScratch, lookHit, recMatch;

  slice_tlb_ctl #(.AW(AW), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .lookScratch(lookScratch),
    .lookHit(lookHit), .recMatch(recMatch), .rspValid(rspValid), .rspFault(rspFault),
    .rspScratch(rspScratch), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .strb(strb)
  );

  slice_tlb_dp #(.AW(AW), .ENTRIES(ENTRIES), .SPM_BYTES(SPM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqVa(reqVa), .memRspData(memRspData),
    .lookScratch(lookScratch), .lookHit(lookHit), .recMatch(recMatch), .rspPa(rspPa)
  );

  // R7
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> (rspPa == '0));

  // R2
  scratch_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspScratch |-> (rspPa < AW'(SPM_BYTES)) && !rspFault);
endmodule

// File: tb/slice_tlb_bench.sv
module slice_tlb_bench;
  logic clk = 0;
  logic rstN = 0;
  logic cfgWrEn = 0, cfgSel = 0;
  logic [31:0] cfgWrData = '0;
  logic reqValid = 0;
  logic reqReady;
  logic [31:0] reqVa = '0;
  logic rspValid, rspFault, rspScratch;
  logic [31:0] rspPa;
  logic memReqValid;
  logic memReqReady = 0;
  logic [31:0] memReqAddr;
  logic memRspValid = 0;
  logic [31:0] memRspData = '0;

  int checks = 0, failures = 0;
  int negCnt = 0, lastRspAt = -10, readCount = 0, curCount = 0;
  logic [31:0] readLog [32];
  logic [31:0] mem [128];
  logic [31:0] recV [6], recP [6], recL [6];
  logic pendRsp = 0;
  logic [31:0] pendAddr = '0;

  always #4 clk = ~clk;

  slice_tlb u_slice_tlb (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa), .rspValid(rspValid),
    .rspPa(rspPa), .rspFault(rspFault), .rspScratch(rspScratch),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // memory model, acts on the falling edge
  always @(negedge clk) begin
    negCnt <= negCnt + 1;
    if (pendRsp) begin
      memRspValid = 1;
      memRspData  = mem[pendAddr[8:2]];
      lastRspAt   = negCnt + 1;
      pendRsp     = 0;
    end else begin
      memRspValid = 0;
    end
    memReqReady = ((negCnt % 3) != 1);
    if (memReqValid && memReqReady) begin
      pendRsp  = 1;
      pendAddr = memReqAddr;
      if (readCount < 32) readLog[readCount] = memReqAddr;
      readCount = readCount + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] val);
    @(negedge clk); #1;
    cfgWrEn = 1; cfgSel = sel; cfgWrData = val;
    @(negedge clk); #1;
    cfgWrEn = 0;
    if (sel) curCount = int'(val);
  endtask

  task automatic translate(input logic [31:0] va, input logic [31:0] expPa, input logic expFault,
                           input logic expScratch, input int expReads, input string tag);
    int waits = 0;
    logic readyLeak = 0;
    @(negedge clk); #1;
    readCount = 0;
    chk(reqReady, {tag, " R8 ready before request"}, 32'(reqReady), 1);
    reqValid = 1; reqVa = va;
    @(negedge clk); #1;
    reqValid = 0;
    while (!rspValid) begin
      if (reqReady) readyLeak = 1;
      waits++;
      @(negedge clk); #1;
    end
    chk(rspPa == expPa, {tag, " pa"}, rspPa, expPa);
    chk(rspFault == expFault, {tag, " fault"}, 32'(rspFault), 32'(expFault));
    chk(rspScratch == expScratch, {tag, " scratch"}, 32'(rspScratch), 32'(expScratch));
    chk(readCount == expReads, {tag, " reads"}, 32'(readCount), 32'(expReads));
    if (expReads == 0) chk(waits == 0, {tag, " R3 latency"}, 32'(waits), 0);
    else chk(negCnt == lastRspAt + 1, {tag, " R6 latency"}, 32'(negCnt), 32'(lastRspAt + 1));
    chk(!readyLeak, {tag, " R8 ready low in walk"}, 32'(readyLeak), 0);
  endtask

  task automatic walkTo(input logic [31:0] va, input int k, input string tag);
    translate(va, recP[k] + (va - recV[k]), 0, 0, 3 * (k + 1), tag);
  endtask

  task automatic hitOn(input logic [31:0] va, input int k, input string tag);
    translate(va, recP[k] + (va - recV[k]), 0, 0, 0, tag);
  endtask

  task automatic faultOn(input logic [31:0] va, input string tag);
    translate(va, 0, 1, 0, 3 * curCount, tag);
  endtask

  task automatic checkOrder(input logic [31:0] base, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] exp;
      exp = base + 32'(12 * (i / 3) + 4 * (i % 3));
      chk(readLog[i] == exp, {tag, " R5 read order"}, readLog[i], exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    recV[0] = 32'h2000; recP[0] = 32'h8000_0000; recL[0] = 32'h1000;
    recV[1] = 32'h5000; recP[1] = 32'h9000_0000; recL[1] = 32'h300;
    recV[2] = 32'h6000; recP[2] = 32'hA000_0000; recL[2] = 32'h2000;
    recV[3] = 32'h9000; recP[3] = 32'hB000_0000; recL[3] = 32'h10;
    recV[4] = 32'hA000; recP[4] = 32'hC000_0000; recL[4] = 32'h4;
    recV[5] = 32'hB000; recP[5] = 32'hD000_0000; recL[5] = 32'h100;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    for (int k = 0; k < 6; k++) begin
      mem[3 * k]     = recV[k];
      mem[3 * k + 1] = recP[k];
      mem[3 * k + 2] = recL[k];
    end
    mem[64] = 32'h2000; mem[65] = 32'h1234_0000; mem[66] = 32'h800;

    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(reqReady == 1, "R1 reqReady", 32'(reqReady), 1);
    chk(rspValid == 0, "R1 rspValid", 32'(rspValid), 0);
    chk(memReqValid == 0, "R1 memReqValid", 32'(memReqValid), 0);
    rstN = 1;
    // R1 / R7: zero count, empty buffer -> immediate fault
    faultOn(32'h2000, "R1 R7 empty count");

    // R2 scratchpad sweep
    for (int a = 0; a < 32'h1000; a += 32'h0F4) begin
      translate(32'(a), 32'(a), 0, 1, 0, "R2 scratch");
    end
    translate(32'hFFF, 32'hFFF, 0, 1, 0, "R2 scratch top");

    cfgWrite(0, 32'h0);
    cfgWrite(1, 32'd6);

    walkTo(32'h2010, 0, "R5 first walk");
    checkOrder(32'h0, 3, "R5 rec0");
    hitOn(32'h2FFF, 0, "R3 R4 last byte hit");
    faultOn(32'h3000, "R4 R7 end of slice");
    faultOn(32'h3000, "R7 not installed");
    faultOn(32'h4FFF, "R4 below base");
    walkTo(32'h9008, 3, "R5 walk rec3");
    checkOrder(32'h0, 12, "R5 rec3");
    walkTo(32'h5000, 1, "R6 walk rec1");
    walkTo(32'h6000, 2, "R6 walk rec2");
    hitOn(32'h2000, 0, "R3 R9 touch e0");
    walkTo(32'hA002, 4, "R9 evict rec3");
    hitOn(32'hA003, 4, "R4 len4 top");
    faultOn(32'hA004, "R4 len4 end");
    walkTo(32'h9000, 3, "R9 rec3 refetched");
    walkTo(32'h5010, 1, "R9 rec1 refetched");
    walkTo(32'h7FFF, 2, "R9 rec2 refetched");
    walkTo(32'h2000, 0, "R9 rec0 refetched");
    hitOn(32'h9000, 3, "R9 rec3 kept");
    hitOn(32'h52FF, 1, "R9 rec1 kept");
    walkTo(32'hB0FF, 5, "R5 last record");

    cfgWrite(0, 32'h0);
    walkTo(32'h9000, 3, "R10 flush by base write");
    cfgWrite(1, 32'd6);
    hitOn(32'h9004, 3, "R10 count write keeps rules");

    cfgWrite(0, 32'h100);
    cfgWrite(1, 32'd1);
    translate(32'h2004, 32'h1234_0004, 0, 0, 3, "R5 R10 second table");
    checkOrder(32'h100, 3, "R5 base 0x100");
    faultOn(32'h2800, "R4 R7 second table end");

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule